// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Victim Buffer

This block serves 32-bit instruction fetches from a direct-mapped line store. A small, fully associative victim buffer sits beside it and keeps recently displaced lines. A fetch that finds its line in the primary store answers in one cycle.

When the primary lookup misses, the block searches every victim entry at once. If a victim entry holds the line, that entry and the primary line trade places, and the word comes back one cycle later with no memory traffic. If neither structure holds the line, the block asks memory for the whole line, which arrives one word per beat. When the primary line about to be overwritten is valid, it is first pushed into the victim buffer at a round-robin position.

Data never moves during a swap or an eviction. All lines live in one shared word RAM. Each primary set and each victim entry owns a pointer to one physical line slot, and a swap or an eviction exchanges pointers only.

Top module: `vc_icache`

## Requirements
- R1: After reset, every primary line and every victim entry is invalid and the replacement pointer is zero. req_ready is 1, and rsp_valid and mem_req_valid are 0. The first fetch of any line goes to memory.
- R2: The fetch address is split into three fields. Bits [7:0] are the byte offset and bits [7:2] select the word. The next IDX_W bits (default 4, bits [11:8]) are the set index, and the bits above them are the tag. Requests are word aligned. A refill request carries the line address with its low 8 bits zero. The returned word is the one that memory delivered for that address.
- R3: A refill request holds mem_req_valid and its address until mem_req_ready is seen. Exactly 64 beats are then taken, and beat k carries word k of the line. A cycle with mem_rsp_valid low stalls the beat count. The fetched word is returned after the last beat.
- R4: A primary hit raises rsp_valid on the cycle after the request is accepted, and makes no memory request.
- R5: The victim buffer is searched only after a primary miss. A victim hit returns the word two cycles after acceptance, with no memory request.
- R6: On a victim hit, the line that was in the primary set moves into the hit victim entry. Its victim tag is the old primary tag joined with the set index, and its valid bit travels with it. A later fetch of that line is again a victim hit.
- R7: On a miss in both structures, a valid primary line is written into the victim entry named by the replacement pointer. The pointer then advances by one modulo 16, so the 17th eviction overwrites the oldest one.
- R8: When the primary line being replaced is invalid, nothing is written to the victim buffer and the pointer does not move.
- R9: A victim hit leaves the replacement pointer unchanged.
- R10: A request is accepted only while req_ready is 1. req_ready is low from acceptance of a missing request until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 32 | Word-aligned fetch address |
| rsp_valid | output | 1 | One-cycle pulse with the fetched word |
| rsp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Line refill request |
| mem_req_ready | input | 1 | Memory accepts the refill request |
| mem_req_addr | output | 32 | Line-aligned refill address |
| mem_rsp_valid | input | 1 | Refill beat present |
| mem_rsp_ready | output | 1 | Block takes refill beats |
| mem_rsp_data | input | 32 | Refill beat data |

## Verification
A corrupted tag, valid bit or slot pointer changes the number of refill requests. It does so on the very next fetch of an affected line: a spurious hit returns a wrong word one or two cycles after acceptance, and a lost line shows up as an extra refill. A replacement pointer that drifts, or that moves on a swap or on an invalid replacement, is silent until the buffer wraps. It then shows up when the set is hammered with more than 16 conflicting lines and a line that should still be buffered misses. The fetch sequence therefore counts memory requests per fetch and times every response.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_MREQ,
    ST_MDATA,
    ST_FILLRD
  } vc_state_e;
endpackage

// File: rtl/vc_line_ram.sv
module vc_line_ram #(
  parameter int WORD_W = 32,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vc_victim_buf.sv
module vc_victim_buf #(
  parameter int LADDR_W = 24,
  parameter int SLOT_W  = 5,
  parameter int VB_N    = 16,
  parameter int SETS    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LADDR_W-1:0] look_laddr,
  output logic               hit,
  output logic [$clog2(VB_N)-1:0] hit_ent,
  output logic [SLOT_W-1:0]  hit_slot,
  output logic [$clog2(VB_N)-1:0] nxt_ent,
  output logic [SLOT_W-1:0]  nxt_slot,
  input  logic               wr_en,
  input  logic               wr_adv,
  input  logic [$clog2(VB_N)-1:0] wr_ent,
  input  logic [LADDR_W-1:0] wr_laddr,
  input  logic               wr_valid,
  input  logic [SLOT_W-1:0]  wr_slot
);
  localparam int VPTR_W = $clog2(VB_N);

  logic [LADDR_W-1:0] v_tag  [VB_N];
  logic [SLOT_W-1:0]  v_slot [VB_N];
  logic [VB_N-1:0]    v_val;
  logic [VB_N-1:0]    match;
  logic [VPTR_W-1:0]  ptr;
  logic [VPTR_W-1:0]  ptr_inc;

  for (genvar e = 0; e < VB_N; e++) begin : g_cmp
    assign match[e] = v_val[e] && (v_tag[e] == look_laddr);
  end

  always_comb begin
    hit_ent = '0;
    for (int e = VB_N - 1; e >= 0; e--) begin
      if (match[e]) hit_ent = VPTR_W'(e);
    end
  end

  assign hit      = |match;
  assign hit_slot = v_slot[hit_ent];
  assign nxt_ent  = ptr;
  assign nxt_slot = v_slot[ptr];
  assign ptr_inc  = (ptr == VPTR_W'(VB_N - 1)) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      v_val <= '0;
      for (int e = 0; e < VB_N; e++) begin
        v_tag[e]  <= '0;
        v_slot[e] <= SLOT_W'(SETS + e);
      end
    end else if (wr_en) begin
      v_tag[wr_ent]  <= wr_laddr;
      v_val[wr_ent]  <= wr_valid;
      v_slot[wr_ent] <= wr_slot;
      if (wr_adv) ptr <= ptr_inc;
    end
  end

  AST_VB_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> (ptr == (($past(ptr) == VPTR_W'(VB_N - 1)) ? '0 : $past(ptr) + 1'b1))); // R7
  AST_SWAP_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_adv) |=> $stable(ptr)); // R9
  AST_EVICT_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_adv) |-> wr_valid); // R8
endmodule

// File: rtl/vc_icache.sv
module vc_icache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFF_W  = 8,
  parameter int IDX_W  = 4,
  parameter int VB_N   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int WSEL_W  = OFF_W - 2;
  localparam int SETS    = 2 ** IDX_W;
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int SLOTS   = SETS + VB_N;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int VPTR_W  = $clog2(VB_N);
  localparam int RAM_AW  = SLOT_W + WSEL_W;

  vc_state_e         state;
  logic [ADDR_W-1:2] rq_addr;
  logic [ADDR_W-1:2] cur_addr;
  logic [WSEL_W-1:0] beat;

  logic [TAG_W-1:0]  p_tag  [SETS];
  logic [SLOT_W-1:0] p_slot [SETS];
  logic [SETS-1:0]   p_val;

  logic [IDX_W-1:0]   c_idx;
  logic [TAG_W-1:0]   c_tag;
  logic [WSEL_W-1:0]  c_wsel;
  logic [LADDR_W-1:0] c_laddr;
  logic               p_hit;

  logic              ram_re, ram_we;
  logic [RAM_AW-1:0] ram_raddr, ram_waddr;

  logic               vb_hit, vb_wr_en, vb_adv, vb_wr_valid;
  logic [VPTR_W-1:0]  vb_hit_ent, vb_nxt_ent, vb_wr_ent;
  logic [SLOT_W-1:0]  vb_hit_slot, vb_nxt_slot, vb_wr_slot;
  logic [LADDR_W-1:0] vb_wr_laddr;

  assign cur_addr = (state == ST_IDLE) ? req_addr[ADDR_W-1:2] : rq_addr;
  assign c_wsel   = cur_addr[OFF_W-1:2];
  assign c_idx    = cur_addr[OFF_W+IDX_W-1:OFF_W];
  assign c_tag    = cur_addr[ADDR_W-1:OFF_W+IDX_W];
  assign c_laddr  = cur_addr[ADDR_W-1:OFF_W];
  assign p_hit    = p_val[c_idx] && (p_tag[c_idx] == c_tag);

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_MREQ);
  assign mem_rsp_ready = (state == ST_MDATA);
  assign mem_req_addr  = {rq_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign ram_we    = (state == ST_MDATA) && mem_rsp_valid;
  assign ram_waddr = {p_slot[c_idx], beat};

  always_comb begin
    ram_re      = 1'b0;
    ram_raddr   = {p_slot[c_idx], c_wsel};
    vb_wr_en    = 1'b0;
    vb_adv      = 1'b0;
    vb_wr_ent   = vb_hit_ent;
    vb_wr_laddr = {p_tag[c_idx], c_idx};
    vb_wr_valid = p_val[c_idx];
    vb_wr_slot  = p_slot[c_idx];
    case (state)
      ST_IDLE:   ram_re = req_valid && p_hit;
      ST_PROBE: begin
        if (vb_hit) begin
          ram_re    = 1'b1;
          ram_raddr = {vb_hit_slot, c_wsel};
          vb_wr_en  = 1'b1;
        end else if (p_val[c_idx]) begin
          vb_wr_en  = 1'b1;
          vb_adv    = 1'b1;
          vb_wr_ent = vb_nxt_ent;
        end
      end
      ST_FILLRD: ram_re = 1'b1;
      default:   ram_re = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      beat      <= '0;
      rq_addr   <= '0;
      p_val     <= '0;
      for (int s = 0; s < SETS; s++) begin
        p_tag[s]  <= '0;
        p_slot[s] <= SLOT_W'(s);
      end
    end else begin
      rsp_valid <= ram_re;
      case (state)
        ST_IDLE: begin
          if (req_valid && !p_hit) begin
            rq_addr <= req_addr[ADDR_W-1:2];
            state   <= ST_PROBE;
          end
        end
        ST_PROBE: begin
          p_tag[c_idx] <= c_tag;
          p_val[c_idx] <= 1'b1;
          if (vb_hit) begin
            p_slot[c_idx] <= vb_hit_slot;
            state         <= ST_IDLE;
          end else begin
            if (p_val[c_idx]) p_slot[c_idx] <= vb_nxt_slot;
            state <= ST_MREQ;
          end
        end
        ST_MREQ: begin
          if (mem_req_ready) begin
            beat  <= '0;
            state <= ST_MDATA;
          end
        end
        ST_MDATA: begin
          if (mem_rsp_valid) begin
            beat <= beat + 1'b1;
            if (beat == {WSEL_W{1'b1}}) state <= ST_FILLRD;
          end
        end
        ST_FILLRD: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  vc_line_ram #(.WORD_W(WORD_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (mem_rsp_data),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (rsp_data)
  );

  vc_victim_buf #(.LADDR_W(LADDR_W), .SLOT_W(SLOT_W), .VB_N(VB_N), .SETS(SETS)) u_vbuf (
    .clk        (clk),
    .rst        (rst),
    .look_laddr (c_laddr),
    .hit        (vb_hit),
    .hit_ent    (vb_hit_ent),
    .hit_slot   (vb_hit_slot),
    .nxt_ent    (vb_nxt_ent),
    .nxt_slot   (vb_nxt_slot),
    .wr_en      (vb_wr_en),
    .wr_adv     (vb_adv),
    .wr_ent     (vb_wr_ent),
    .wr_laddr   (vb_wr_laddr),
    .wr_valid   (vb_wr_valid),
    .wr_slot    (vb_wr_slot)
  );

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && p_hit) |=> rsp_valid); // R4
  AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_req_valid && !mem_rsp_ready)); // R10
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R3
  AST_PROBE_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROBE) |-> $past(req_valid && req_ready && !p_hit)); // R5
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> (req_addr[1:0] == 2'b00)); // R2
endmodule

// File: tb/vc_icache_bench.sv
`timescale 1ns/1ps
module vc_icache_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  int tests = 0;
  int fails = 0;
  int mem_cnt = 0;
  logic [31:0] last_la = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #4 clk = ~clk;

  vc_icache u_vc_icache (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int w);
    return {t[19:0], s[3:0], w[5:0], 2'b00};
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] a);
    return {a[31:2], 2'b01};
  endfunction

  // memory model: one wait cycle on the request, one stall inside the burst (R3)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req_valid && !mem_req_ready) begin
        mem_cnt++;
        last_la = mem_req_addr;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int b = 0; b < 64; b++) begin
          if (b == 20) begin
            mem_rsp_valid = 1'b0;
            @(negedge clk);
          end
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = {last_la[31:8], b[5:0], 2'b01};
          @(negedge clk);
        end
        mem_rsp_valid = 1'b0;
        chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R3", "early response before final read", rsp_valid, 0);
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected response", rsp_data, 0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data == e, t, "response data", rsp_data, e);
      end
    end
  end

  // kind: 0 primary hit, 1 victim hit, 2 miss in both
  task automatic fetch(input logic [31:0] a, input int kind, input string req);
    int mc0;
    int cyc;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "idle before request", req_ready, 1);
    mc0 = mem_cnt;
    exp_q.push_back(word_of(a));
    tag_q.push_back(req);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (kind != 0) chk(req_ready == 1'b0, "R10", "busy after a primary miss", req_ready, 0);
    while (!rsp_valid) begin
      @(negedge clk);
      cyc++;
    end
    if (kind == 0) chk(cyc == 1, req, "primary hit latency", cyc, 1);
    else if (kind == 1) chk(cyc == 2, req, "victim hit latency", cyc, 2);
    else chk(cyc > 66, req, "refill latency", cyc, 67);
    chk((mem_cnt - mc0) == ((kind == 2) ? 1 : 0), req, "memory request count",
        mem_cnt - mc0, (kind == 2) ? 1 : 0);
    if (kind == 2) chk(last_la == {a[31:8], 8'h00}, "R2", "refill line address", last_la, {a[31:8], 8'h00});
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", mem_req_valid, 0);

    fetch(mk(1, 0, 5), 2, "R1");    // A: first fetch misses
    fetch(mk(1, 0, 63), 0, "R4");   // last word of line A
    fetch(mk(1, 0, 0), 0, "R2");    // first word of line A
    fetch(mk(2, 0, 7), 2, "R7");    // B evicts A into victim entry 0
    fetch(mk(1, 0, 9), 1, "R5");    // A found in victim buffer
    fetch(mk(2, 0, 3), 1, "R6");    // B was swapped out, found again
    fetch(mk(1, 0, 11), 1, "R6");   // A back in primary, B in entry 0
    fetch(mk(5, 1, 0), 2, "R8");    // invalid primary in set 1: no eviction
    fetch(mk(3, 0, 1), 2, "R7");    // C: A to entry 1
    for (int i = 1; i <= 14; i++) fetch(mk(10 + i, 0, i), 2, "R7");
    fetch(mk(2, 0, 4), 1, "R9");    // B still in entry 0 only if pointer held
    fetch(mk(40, 0, 2), 2, "R7");   // E: B overwrites oldest entry 0 (D14)
    fetch(mk(1, 0, 12), 1, "R7");   // A still in entry 1
    fetch(mk(24, 0, 6), 2, "R7");   // D14 was overwritten: refill
    fetch(mk(5, 1, 2), 0, "R4");    // set 1 untouched by set 0 traffic
    fetch(mk(24, 0, 60), 0, "R2");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
    done = 1'b1;
    finish_up();
  end
endmodule